// File: doc/BRIEF.md
# Multi-Thread Instruction Line Fetch Controller

This block sits in the front end of a multi-threaded core. It keeps one line of instruction bytes per hardware thread. Each buffer has a valid bit and a tag holding the line-aligned address. Every cycle, at most one thread presents a fetch PC. If that thread's buffer already holds the line, the fetch hits and no memory traffic occurs. If not, the controller issues a read of the whole line. It records the new tag and invalidates the buffer until the data comes back.

Memory may refuse a request. A refused request is parked in a single retry slot shared by all threads. A cache-blocked flag then holds off every new line fetch until the memory side signals a retry. Each request carries a small tag: the thread id plus a per-thread sequence bit. A returning line is therefore accepted only if its thread is still waiting and the tag matches the latest request. All other returns are counted and discarded. A squash of a thread does three things: it abandons that thread's outstanding work, returns the thread to running, and empties the retry slot if the slot belongs to that thread.

Thread state codes on `threadState` (three bits per thread, thread t at bits 3t+2..3t): 0 running, 1 waiting for retry, 2 waiting for response, 3 access complete, 4 blocked.

Top module: `fetch_line_ctrl`

## Requirements
- R1: A line read is issued at the fetch PC with its low log2(line bytes) bits cleared (16-byte lines: low 4 bits zero).
- R2: A fetch from a running thread whose buffer is valid, and whose tag equals the aligned PC, raises `fetchHit` in the same cycle, drives `lineRdData` with that thread's line and issues no request.
- R3: A fetch that misses drives `memReqValid` in the same cycle. The request tag is {thread id, inverted sequence bit}, with the sequence bit in bit 0. After the clock edge the thread's `lineValid` is 0. If `memReqAccept` was high, the thread is in state 2.
- R4: A miss refused by memory (`memReqAccept` low) puts the thread in state 1 and sets `cacheBlocked`. While `cacheBlocked` is set, no fetch from any thread issues a request.
- R5: `memRetry` with the slot occupied resends the same address and tag. If that resend is accepted, the thread moves to state 2 and `cacheBlocked` clears. `memRetry` with the slot empty issues nothing and only clears `cacheBlocked`.
- R6: A response is taken only if its thread is in state 2 and its tag equals that thread's latest request tag. The line is stored, `lineValid` is set, and the thread goes to state 3, or to state 4 when its stall input is high. State 3 returns to state 0 one cycle later.
- R7: Any response not taken leaves every buffer unchanged and increments `dropCount` by one.
- R8: A squash puts the thread in state 0 after the edge and forgets its outstanding request. A response arriving later, or in the same cycle, is dropped. If the retry slot belongs to that thread, the slot is emptied, but `cacheBlocked` stays set until the next `memRetry`.
- R9: While `intPending` is high, a fetch whose PC has bits [1:0] equal to 00 issues nothing. A fetch with non-zero low bits proceeds normally.
- R10: A running thread with its stall input high issues no fetch and enters state 4. It returns to state 0 in the cycle after its stall input drops.
- R11: After reset every thread is in state 0, all `lineValid` bits are 0, `cacheBlocked` is 0 and `dropCount` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| fetchValid | input | 1 | A fetch is presented this cycle |
| fetchTid | input | TID_W | Thread of the fetch |
| fetchPc | input | ADDR_W | Fetch program counter |
| intPending | input | 1 | Interrupt pending; gates fetches with PC[1:0]=00 |
| stallIn | input | NUM_THREADS | Per-thread stall from later stages |
| squashIn | input | NUM_THREADS | Per-thread squash |
| memReqValid | output | 1 | Line read request |
| memReqAddr | output | ADDR_W | Line-aligned request address |
| memReqTag | output | TAG_W | {thread id, sequence bit} |
| memReqAccept | input | 1 | Memory takes the request this cycle |
| memRetry | input | 1 | Memory can take the parked request now |
| memRespValid | input | 1 | Line response valid |
| memRespTag | input | TAG_W | Tag of the response |
| memRespData | input | LINE_W | Line data |
| fetchHit | output | 1 | Fetch hit its thread's buffer |
| lineRdData | output | LINE_W | Buffer contents of `fetchTid` |
| lineValid | output | NUM_THREADS | Per-thread buffer valid |
| threadState | output | 3*NUM_THREADS | Per-thread state codes |
| cacheBlocked | output | 1 | Refused request outstanding; new fetches held |
| dropCount | output | CNT_W | Count of discarded responses (wraps) |

## Verification
The risky overlaps are a squash landing in the same cycle as a matching response, and a squash landing while the thread owns the retry slot just before `memRetry`. The bench lines up a response whose tag matches with `squashIn` for that thread in one cycle. It then expects the buffer to stay invalid, the thread to be in state 0 and `dropCount` to step by one. For the slot case it squashes the parked thread and then raises `memRetry` with acceptance. It expects no request to go out and `cacheBlocked` to drop only on that retry.

// File: rtl/fetch_line_pkg.sv
package fetch_line_pkg;
  parameter int NUM_THREADS = 2;
  parameter int ADDR_W      = 32;
  parameter int LINE_BYTES  = 16;
  parameter int CNT_W       = 8;

  localparam int TID_W  = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1;
  localparam int TAG_W  = TID_W + 1;
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int HI_W   = ADDR_W - OFF_W;
  localparam int LINE_W = LINE_BYTES * 8;

  typedef enum logic [2:0] {
    ST_RUN        = 3'd0,
    ST_WAIT_RETRY = 3'd1,
    ST_WAIT_RESP  = 3'd2,
    ST_DONE       = 3'd3,
    ST_BLOCKED    = 3'd4
  } thr_state_e;

  // strobes from control to datapath, valid for one cycle
  typedef struct packed {
    logic newMiss;    // issue a fresh line read for fetchTid
    logic resend;     // drive the parked request onto the memory port
    logic slotLoad;   // park the fresh request (refused)
    logic slotClear;  // empty the retry slot
    logic setBlocked;
    logic clrBlocked;
    logic fill;       // store response into its thread's buffer
    logic drop;       // response discarded
  } ctl_strobe_t;
endpackage

// File: rtl/fetch_line_ctl.sv
module fetch_line_ctl
  import fetch_line_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   fetchValid,
  input  logic [TID_W-1:0]       fetchTid,
  input  logic [1:0]             pcLow,
  input  logic                   intPending,
  input  logic [NUM_THREADS-1:0] stallIn,
  input  logic [NUM_THREADS-1:0] squashIn,
  input  logic                   memReqAccept,
  input  logic                   memRetry,
  input  logic                   memRespValid,
  input  logic [TAG_W-1:0]       memRespTag,
  input  logic                   hitNow,
  input  logic                   respSeqOk,
  input  logic                   slotValid,
  input  logic [TID_W-1:0]       slotTid,
  input  logic                   cacheBlocked,
  output ctl_strobe_t            strb,
  output logic                   fetchHit,
  output thr_state_e             stateVec [NUM_THREADS]
);

  thr_state_e stateQ [NUM_THREADS];
  logic [TID_W-1:0] respTid;
  logic fetchTry, resendGo, fillGo;
  logic [NUM_THREADS-1:0] waitRetryVec;

  assign respTid = memRespTag[TAG_W-1:1];

  always_comb begin
    fetchTry = fetchValid
            && (stateQ[fetchTid] == ST_RUN)
            && !stallIn[fetchTid]
            && !squashIn[fetchTid]
            && !cacheBlocked
            && !(intPending && (pcLow == 2'b00));
    resendGo = memRetry && slotValid && !squashIn[slotTid];
    fillGo   = memRespValid
            && (stateQ[respTid] == ST_WAIT_RESP)
            && respSeqOk
            && !squashIn[respTid];

    fetchHit        = fetchTry && hitNow;
    strb.newMiss    = fetchTry && !hitNow;
    strb.slotLoad   = fetchTry && !hitNow && !memReqAccept;
    strb.setBlocked = fetchTry && !hitNow && !memReqAccept;
    strb.resend     = resendGo;
    strb.slotClear  = (resendGo && memReqAccept) || (slotValid && squashIn[slotTid]);
    strb.clrBlocked = memRetry && (!resendGo || memReqAccept);
    strb.fill       = fillGo;
    strb.drop       = memRespValid && !fillGo;
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    thr_state_e nxt;
    logic isNew, isResent, isFill;

    always_comb begin
      isNew    = strb.newMiss && (fetchTid == TID_W'(t));
      isResent = resendGo && memReqAccept && (slotTid == TID_W'(t));
      isFill   = fillGo && (respTid == TID_W'(t));
      nxt      = stateQ[t];
      if (squashIn[t]) begin
        nxt = ST_RUN;
      end else if (isFill) begin
        nxt = stallIn[t] ? ST_BLOCKED : ST_DONE;
      end else if (isResent) begin
        nxt = ST_WAIT_RESP;
      end else if (isNew) begin
        nxt = memReqAccept ? ST_WAIT_RESP : ST_WAIT_RETRY;
      end else begin
        case (stateQ[t])
          ST_RUN:     nxt = stallIn[t] ? ST_BLOCKED : ST_RUN;
          ST_DONE:    nxt = stallIn[t] ? ST_BLOCKED : ST_RUN;
          ST_BLOCKED: nxt = stallIn[t] ? ST_BLOCKED : ST_RUN;
          ST_WAIT_RETRY, ST_WAIT_RESP: nxt = stateQ[t];
          default:    nxt = ST_RUN;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stateQ[t] <= ST_RUN;
      else       stateQ[t] <= nxt;
    end

    assign waitRetryVec[t] = (stateQ[t] == ST_WAIT_RETRY);
    assign stateVec[t]     = stateQ[t];

    // R8: a squash always leaves the thread running
    a_r8_squash_to_run: assert property (@(posedge clk) disable iff (!rstN)
      squashIn[t] |=> (stateQ[t] == ST_RUN));

    // R10: a running stalled thread becomes blocked
    a_r10_stall_blocks: assert property (@(posedge clk) disable iff (!rstN)
      (stateQ[t] == ST_RUN) && stallIn[t] && !squashIn[t] |=> (stateQ[t] == ST_BLOCKED));
  end

  // R4: the single retry slot means at most one thread waits for retry
  a_r4_single_retry_waiter: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(waitRetryVec));

  // R10: no fresh request from a stalled thread
  a_r10_no_fetch_stalled: assert property (@(posedge clk) disable iff (!rstN)
    fetchValid && stallIn[fetchTid] |-> !strb.newMiss);

endmodule

// File: rtl/fetch_line_dp.sv
module fetch_line_dp
  import fetch_line_pkg::*;
(
  input  logic                   clk,
  input  logic                   rstN,
  input  ctl_strobe_t            strb,
  input  logic [TID_W-1:0]       fetchTid,
  input  logic [ADDR_W-1:0]      fetchPc,
  input  logic [TAG_W-1:0]       memRespTag,
  input  logic [LINE_W-1:0]      memRespData,
  output logic                   hitNow,
  output logic                   respSeqOk,
  output logic                   slotValid,
  output logic [TID_W-1:0]       slotTid,
  output logic                   cacheBlocked,
  output logic                   memReqValid,
  output logic [ADDR_W-1:0]      memReqAddr,
  output logic [TAG_W-1:0]       memReqTag,
  output logic [NUM_THREADS-1:0] lineValid,
  output logic [LINE_W-1:0]      lineRdData,
  output logic [CNT_W-1:0]       dropCount
);

  logic [LINE_W-1:0]      lineData [NUM_THREADS];
  logic [HI_W-1:0]        lineTag  [NUM_THREADS];
  logic [NUM_THREADS-1:0] lineValidQ;
  logic [NUM_THREADS-1:0] seqQ;
  logic                   slotValidQ;
  logic [TID_W-1:0]       slotTidQ;
  logic [HI_W-1:0]        slotHiQ;
  logic                   blockedQ;
  logic [CNT_W-1:0]       dropCountQ;
  logic [HI_W-1:0]        fetchHi;
  logic [TID_W-1:0]       respTid;
  logic                   unusedPcBits;

  assign fetchHi      = fetchPc[ADDR_W-1:OFF_W];
  assign unusedPcBits = ^fetchPc[OFF_W-1:0];
  assign respTid      = memRespTag[TAG_W-1:1];

  assign hitNow     = lineValidQ[fetchTid] && (lineTag[fetchTid] == fetchHi);
  assign respSeqOk  = (memRespTag[0] == seqQ[respTid]);
  assign lineRdData = lineData[fetchTid];

  always_comb begin
    memReqValid = strb.newMiss || strb.resend;
    if (strb.resend) begin
      memReqAddr = {slotHiQ, {OFF_W{1'b0}}};
      memReqTag  = {slotTidQ, seqQ[slotTidQ]};
    end else begin
      memReqAddr = {fetchHi, {OFF_W{1'b0}}};
      memReqTag  = {fetchTid, ~seqQ[fetchTid]};
    end
  end

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_buf
    logic missHere, fillHere;
    assign missHere = strb.newMiss && (fetchTid == TID_W'(t));
    assign fillHere = strb.fill && (respTid == TID_W'(t));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lineValidQ[t] <= 1'b0;
        seqQ[t]       <= 1'b0;
        lineTag[t]    <= '0;
      end else if (missHere) begin
        lineValidQ[t] <= 1'b0;
        seqQ[t]       <= ~seqQ[t];
        lineTag[t]    <= fetchHi;
      end else if (fillHere) begin
        lineValidQ[t] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fillHere) lineData[t] <= memRespData;
    end

    // R6: a buffer only turns valid right after a taken response for it
    a_r6_valid_from_fill: assert property (@(posedge clk) disable iff (!rstN)
      $rose(lineValidQ[t]) |-> $past(strb.fill) && ($past(respTid) == TID_W'(t)));
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValidQ <= 1'b0;
      slotTidQ   <= '0;
      slotHiQ    <= '0;
      blockedQ   <= 1'b0;
      dropCountQ <= '0;
    end else begin
      if (strb.slotLoad) begin
        slotValidQ <= 1'b1;
        slotTidQ   <= fetchTid;
        slotHiQ    <= fetchHi;
      end else if (strb.slotClear) begin
        slotValidQ <= 1'b0;
      end
      if (strb.setBlocked)      blockedQ <= 1'b1;
      else if (strb.clrBlocked) blockedQ <= 1'b0;
      if (strb.drop) dropCountQ <= dropCountQ + CNT_W'(1);
    end
  end

  assign slotValid    = slotValidQ;
  assign slotTid      = slotTidQ;
  assign cacheBlocked = blockedQ;
  assign lineValid    = lineValidQ;
  assign dropCount    = dropCountQ;

  // R4: while blocked only the parked request may use the port
  a_r4_blocked_quiet: assert property (@(posedge clk) disable iff (!rstN)
    blockedQ && !strb.resend |-> !memReqValid);

  // R3: a fresh miss invalidates its buffer
  a_r3_miss_invalidates: assert property (@(posedge clk) disable iff (!rstN)
    strb.newMiss |=> !lineValidQ[$past(fetchTid)]);

  // R7: each dropped response bumps the counter once
  a_r7_drop_counts: assert property (@(posedge clk) disable iff (!rstN)
    strb.drop |=> dropCountQ == $past(dropCountQ) + CNT_W'(1));

  // R5: a parked request exists only while blocked
  a_r5_slot_implies_blocked: assert property (@(posedge clk) disable iff (!rstN)
    slotValidQ |-> blockedQ);

endmodule

// File: rtl/fetch_line_ctrl.sv
module fetch_line_ctrl
  import fetch_line_pkg::*;
(
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     fetchValid,
  input  logic [TID_W-1:0]         fetchTid,
  input  logic [ADDR_W-1:0]        fetchPc,
  input  logic                     intPending,
  input  logic [NUM_THREADS-1:0]   stallIn,
  input  logic [NUM_THREADS-1:0]   squashIn,
  output logic                     memReqValid,
  output logic [ADDR_W-1:0]        memReqAddr,
  output logic [TAG_W-1:0]         memReqTag,
  input  logic                     memReqAccept,
  input  logic                     memRetry,
  input  logic                     memRespValid,
  input  logic [TAG_W-1:0]         memRespTag,
  input  logic [LINE_W-1:0]        memRespData,
  output logic                     fetchHit,
  output logic [LINE_W-1:0]        lineRdData,
  output logic [NUM_THREADS-1:0]   lineValid,
  output logic [3*NUM_THREADS-1:0] threadState,
  output logic                     cacheBlocked,
  output logic [CNT_W-1:0]         dropCount
);

  ctl_strobe_t      strb;
  logic             hitNow, respSeqOk, slotValid;
  logic [TID_W-1:0] slotTid;
  thr_state_e       stateVec [NUM_THREADS];

  fetch_line_ctl u_ctl (
    .clk          (clk),
    .rstN         (rstN),
    .fetchValid   (fetchValid),
    .fetchTid     (fetchTid),
    .pcLow        (fetchPc[1:0]),
    .intPending   (intPending),
    .stallIn      (stallIn),
    .squashIn     (squashIn),
    .memReqAccept (memReqAccept),
    .memRetry     (memRetry),
    .memRespValid (memRespValid),
    .memRespTag   (memRespTag),
    .hitNow       (hitNow),
    .respSeqOk    (respSeqOk),
    .slotValid    (slotValid),
    .slotTid      (slotTid),
    .cacheBlocked (cacheBlocked),
    .strb         (strb),
    .fetchHit     (fetchHit),
    .stateVec     (stateVec)
  );

  fetch_line_dp u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strb         (strb),
    .fetchTid     (fetchTid),
    .fetchPc      (fetchPc),
    .memRespTag   (memRespTag),
    .memRespData  (memRespData),
    .hitNow       (hitNow),
    .respSeqOk    (respSeqOk),
    .slotValid    (slotValid),
    .slotTid      (slotTid),
    .cacheBlocked (cacheBlocked),
    .memReqValid  (memReqValid),
    .memReqAddr   (memReqAddr),
    .memReqTag    (memReqTag),
    .lineValid    (lineValid),
    .lineRdData   (lineRdData),
    .dropCount    (dropCount)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_state
    assign threadState[3*t +: 3] = stateVec[t];
  end

endmodule

// File: tb/tb_fetch_line_ctrl.sv
module tb_fetch_line_ctrl;
  import fetch_line_pkg::*;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN;
  logic fetchValid;
  logic [TID_W-1:0] fetchTid;
  logic [ADDR_W-1:0] fetchPc;
  logic intPending;
  logic [NUM_THREADS-1:0] stallIn, squashIn;
  logic memReqValid;
  logic [ADDR_W-1:0] memReqAddr;
  logic [TAG_W-1:0] memReqTag;
  logic memReqAccept, memRetry, memRespValid;
  logic [TAG_W-1:0] memRespTag;
  logic [LINE_W-1:0] memRespData;
  logic fetchHit;
  logic [LINE_W-1:0] lineRdData;
  logic [NUM_THREADS-1:0] lineValid;
  logic [3*NUM_THREADS-1:0] threadState;
  logic cacheBlocked;
  logic [CNT_W-1:0] dropCount;

  int nTests = 0;
  int nFails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fetch_line_ctrl dut (
    .clk(clk), .rstN(rstN), .fetchValid(fetchValid), .fetchTid(fetchTid),
    .fetchPc(fetchPc), .intPending(intPending), .stallIn(stallIn),
    .squashIn(squashIn), .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memReqTag(memReqTag), .memReqAccept(memReqAccept), .memRetry(memRetry),
    .memRespValid(memRespValid), .memRespTag(memRespTag),
    .memRespData(memRespData), .fetchHit(fetchHit), .lineRdData(lineRdData),
    .lineValid(lineValid), .threadState(threadState),
    .cacheBlocked(cacheBlocked), .dropCount(dropCount)
  );

  task automatic chk(input string req, input logic [LINE_W-1:0] act,
                     input logic [LINE_W-1:0] exp);
    nTests++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic logic [2:0] st(input int t);
    return threadState[3*t +: 3];
  endfunction

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic idle();
    fetchValid = 0; fetchTid = '0; fetchPc = '0; intPending = 0;
    stallIn = '0; squashIn = '0; memReqAccept = 0; memRetry = 0;
    memRespValid = 0; memRespTag = '0; memRespData = '0;
  endtask

  task automatic presentFetch(input int tid, input logic [ADDR_W-1:0] pc);
    fetchValid = 1; fetchTid = TID_W'(tid); fetchPc = pc;
  endtask

  task automatic sendResp(input logic [TAG_W-1:0] tag, input logic [LINE_W-1:0] d);
    memRespValid = 1; memRespTag = tag; memRespData = d;
  endtask

  task automatic t_reset();
    chk("R11 state0", st(0), 0);
    chk("R11 state1", st(1), 0);
    chk("R11 lineValid", lineValid, 0);
    chk("R11 cacheBlocked", cacheBlocked, 0);
    chk("R11 dropCount", dropCount, 0);
    chk("R11 no request", memReqValid, 0);
  endtask

  task automatic t_miss_then_hit();
    idle(); presentFetch(0, 32'h1234); memReqAccept = 1; #1;
    chk("R3 req valid", memReqValid, 1);
    chk("R1 aligned addr", memReqAddr, 32'h1230);
    chk("R3 req tag", memReqTag, 2'b01);
    chk("R2 no hit on miss", fetchHit, 0);
    tick(); idle();
    chk("R3 waiting resp", st(0), 2);
    chk("R3 buffer invalid", lineValid[0], 0);
    sendResp(2'b01, 128'hA5A5_0001); tick(); idle();
    chk("R6 filled", lineValid[0], 1);
    chk("R6 access complete", st(0), 3);
    tick();
    chk("R6 back to run", st(0), 0);
    presentFetch(0, 32'h123C); #1;
    chk("R2 hit", fetchHit, 1);
    chk("R2 no request", memReqValid, 0);
    chk("R2 line data", lineRdData, 128'hA5A5_0001);
    tick(); idle();
  endtask

  task automatic t_stale();
    idle(); presentFetch(1, 32'h2000); memReqAccept = 1; #1;
    chk("R3 thread1 tag", memReqTag, 2'b11);
    tick(); idle();
    sendResp(2'b10, 128'hDEAD); tick(); idle();
    chk("R7 seq mismatch dropped", dropCount, 1);
    chk("R7 buffer untouched", lineValid[1], 0);
    chk("R7 still waiting", st(1), 2);
    sendResp(2'b01, 128'hBEEF); tick(); idle();
    chk("R7 idle thread resp dropped", dropCount, 2);
    chk("R7 thread0 line kept", lineValid[0], 1);
    sendResp(2'b11, 128'h7777); tick(); idle();
    chk("R6 thread1 filled", lineValid[1], 1);
    tick();
  endtask

  task automatic t_retry();
    idle(); presentFetch(0, 32'h4008); memReqAccept = 0; #1;
    chk("R1 aligned refused addr", memReqAddr, 32'h4000);
    chk("R3 tag toggled back", memReqTag, 2'b00);
    tick(); idle();
    chk("R4 wait retry", st(0), 1);
    chk("R4 blocked", cacheBlocked, 1);
    presentFetch(1, 32'h5000); memReqAccept = 1; #1;
    chk("R4 other thread held", memReqValid, 0);
    tick(); idle();
    chk("R4 other thread running", st(1), 0);
    memRetry = 1; memReqAccept = 0; #1;
    chk("R5 resend valid", memReqValid, 1);
    chk("R5 resend addr", memReqAddr, 32'h4000);
    chk("R5 resend tag", memReqTag, 2'b00);
    tick();
    chk("R5 refused again waits", st(0), 1);
    chk("R5 still blocked", cacheBlocked, 1);
    memReqAccept = 1; #1;
    chk("R5 resend again", memReqValid, 1);
    tick(); idle();
    chk("R5 now waiting resp", st(0), 2);
    chk("R5 unblocked", cacheBlocked, 0);
  endtask

  task automatic t_squash_wait();
    idle(); squashIn[0] = 1; tick(); idle();
    chk("R8 squash to run", st(0), 0);
    sendResp(2'b00, 128'h1111); tick(); idle();
    chk("R8 late resp dropped", lineValid[0], 0);
    chk("R8 late resp counted", dropCount, 3);
  endtask

  task automatic t_squash_slot();
    idle(); presentFetch(1, 32'h6000); memReqAccept = 0; tick(); idle();
    chk("R4 thread1 parked", st(1), 1);
    squashIn[1] = 1; tick(); idle();
    chk("R8 parked thread runs", st(1), 0);
    chk("R8 blocked stays", cacheBlocked, 1);
    memRetry = 1; memReqAccept = 1; #1;
    chk("R5 empty slot no request", memReqValid, 0);
    tick(); idle();
    chk("R5 empty retry unblocks", cacheBlocked, 0);
  endtask

  task automatic t_squash_same_cycle();
    idle(); presentFetch(0, 32'h8000); memReqAccept = 1; #1;
    chk("R3 tag thread0", memReqTag, 2'b01);
    tick(); idle();
    sendResp(2'b01, 128'h2222); squashIn[0] = 1; tick(); idle();
    chk("R8 same-cycle resp not taken", lineValid[0], 0);
    chk("R8 same-cycle state", st(0), 0);
    chk("R8 same-cycle dropped", dropCount, 4);
  endtask

  task automatic t_interrupt_and_stall_fill();
    idle(); intPending = 1; presentFetch(0, 32'h9000); memReqAccept = 1; #1;
    chk("R9 held on aligned pc", memReqValid, 0);
    tick();
    chk("R9 thread still running", st(0), 0);
    fetchPc = 32'h9002; #1;
    chk("R9 proceeds low bits set", memReqValid, 1);
    chk("R9 aligned", memReqAddr, 32'h9000);
    tick(); idle();
    sendResp(2'b00, 128'h3333); stallIn[0] = 1; tick();
    memRespValid = 0;
    chk("R6 stalled fill blocks", st(0), 4);
    chk("R6 stalled fill valid", lineValid[0], 1);
    tick();
    chk("R10 stays blocked", st(0), 4);
    stallIn[0] = 0; tick();
    chk("R10 resumes", st(0), 0);
  endtask

  task automatic t_stall();
    idle(); stallIn[1] = 1; presentFetch(1, 32'hA000); memReqAccept = 1; #1;
    chk("R10 stalled no fetch", memReqValid, 0);
    tick();
    chk("R10 enters blocked", st(1), 4);
    idle(); tick();
    chk("R10 back to run", st(1), 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nTests++; nFails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    #1;
    t_reset();
    t_miss_then_hit();
    t_stale();
    t_retry();
    t_squash_wait();
    t_squash_slot();
    t_squash_same_cycle();
    t_interrupt_and_stall_fill();
    t_stall();
    $display("[TB] %0d tests run, %0d failed", nTests, nFails);
    $finish;
  end
endmodule